// File: doc/BRIEF.md
# Translation Cache Status Tracker

This block holds one status byte for each slot of a translated-instruction cache in an emulation assist. When the translator produces code for a simulated instruction, the block marks the slot where the instruction starts as translated. It also flags the slots that follow, up to the instruction's span, as continuations. Stores made by the simulated program are reported to the block, which marks the target slot as modified. If that slot is a continuation, the block carries the mark backwards, one slot per cycle, until it reaches the slot where the instruction starts.

The execution front end reads a slot's status through a lookup port. It learns in one cycle whether the stored translation can be reused, whether the instruction must be decoded again, or whether the slot holds an external subroutine call. An entry strobe carries the simulated program counter. When that counter's top bit is set, the whole table is wiped and the counter is handed back with the bit cleared.

Top module: `xlat_status_tracker`

## Requirements
- R1: After reset every status byte reads 8'h00, `busy` is low and `lk_ack` is low.
- R2: An accepted translate write sets the head slot's byte to {bit7 translated=1, bit6 modified=0, bit5 continuation=0, bit4 = `tr_ext`, bits3:0 = `tr_len`}.
- R3: The same write sets each slot from head+1 to head+`tr_span`-1, with the index taken modulo the slot count, to 8'h20 (only the continuation bit 5 set). A span of 0 or 1 writes the head slot only.
- R4: An accepted store sets bit 6 of the slot at `st_addr`, whether or not that slot is translated, and leaves its other bits unchanged.
- R5: A store into a slot whose bit 5 is set raises `busy` on the next edge. Then, on each edge, bit 6 is set on the preceding slot (wrapping modulo the slot count), ending with the first slot reached whose bit 5 is clear. That slot is included. `busy` stays high for exactly one cycle per slot walked, and for no more than slot count minus one cycles.
- R6: An accepted lookup returns, one edge later, `lk_ack`=1 and `lk_data` = the slot's byte. `lk_reuse` is high when bit7 is set and bits 6 and 5 are clear. `lk_redecode` is high when bits 7 and 6 are both set.
- R7: `lk_units` shows the length field of the looked-up byte. A field of 0 reads as 16 when `UNITS_PER_SLOT` is 16, and as 0 otherwise.
- R8: `clear_all` sets every byte to 8'h00 on the next edge and ends any walk in progress. It takes priority over translates and stores in the same cycle.
- R9: `entry_stb` loads `pc_out` with `entry_pc` with its top bit forced to 0. If that top bit was 1, every byte is cleared as with `clear_all`; if it was 0, the table is unchanged.
- R10: While `busy` is high, lookups are not acknowledged, and translate writes and stores are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_all | input | 1 | Synchronous wipe of all status bytes |
| entry_stb | input | 1 | Entry strobe carrying the simulated program counter |
| entry_pc | input | PC_W | Simulated program counter at entry |
| pc_out | output | PC_W | Program counter with top bit cleared |
| tr_valid | input | 1 | Translate write request |
| tr_head | input | max(LOG_SLOTS,1) | Head slot index |
| tr_span | input | SPAN_W | Number of slots the instruction covers |
| tr_ext | input | 1 | Translation is an external subroutine call |
| tr_len | input | 4 | Coded length in alignment units |
| st_valid | input | 1 | Simulated store observed |
| st_addr | input | max(LOG_SLOTS,1) | Slot index hit by the store |
| busy | output | 1 | Backward modification walk in progress |
| lk_valid | input | 1 | Lookup request |
| lk_idx | input | max(LOG_SLOTS,1) | Slot index to look up |
| lk_ack | output | 1 | Lookup result valid |
| lk_data | output | 8 | Status byte of the looked-up slot |
| lk_reuse | output | 1 | Translation may be reused |
| lk_redecode | output | 1 | Instruction must be decoded again |
| lk_units | output | 5 | Decoded unit count |

## Verification
A vector table covers four kinds of activity:
- Multi-slot translations, which separate head bytes from continuation bytes.
- Stores to untranslated slots, which show that the modified bit does not depend on the translated bit.
- Stores to head slots, which must not start a walk.
- Stores to tail slots, one of them across the top-to-bottom index wrap, which show that the walk stops at the head and not before or after.

Directed tests count the cycles `busy` is high for a known span. They issue lookups, stores and translates inside that window to show that each is refused. They compare entry strobes with the top bit set and with it clear, to tell a wipe from a plain counter load. They also check the zero-length decode.

// File: rtl/xlat_status_tracker.sv
`timescale 1ns/1ps
module xlat_status_tracker #(
  parameter int LOG_SLOTS      = 4,
  parameter int SPAN_W         = 3,
  parameter int UNITS_PER_SLOT = 16,
  parameter int PC_W           = 16,
  localparam int SLOTS    = 1 << LOG_SLOTS,
  localparam int IW       = (LOG_SLOTS > 0) ? LOG_SLOTS : 1,
  localparam int MAX_SPAN = (1 << SPAN_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_all,
  input  logic              entry_stb,
  input  logic [PC_W-1:0]   entry_pc,
  output logic [PC_W-1:0]   pc_out,
  input  logic              tr_valid,
  input  logic [IW-1:0]     tr_head,
  input  logic [SPAN_W-1:0] tr_span,
  input  logic              tr_ext,
  input  logic [3:0]        tr_len,
  input  logic              st_valid,
  input  logic [IW-1:0]     st_addr,
  output logic              busy,
  input  logic              lk_valid,
  input  logic [IW-1:0]     lk_idx,
  output logic              lk_ack,
  output logic [7:0]        lk_data,
  output logic              lk_reuse,
  output logic              lk_redecode,
  output logic [4:0]        lk_units
);
  localparam logic [IW-1:0] MASK = IW'(SLOTS - 1);
  localparam logic [4:0]    ZERO_LEN_UNITS = (UNITS_PER_SLOT == 16) ? 5'd16 : 5'd0;

  logic [7:0]    tbl [SLOTS];
  logic [IW-1:0] walk_ptr;
  logic [IW:0]   walk_cnt;

  wire          flush   = clear_all | (entry_stb & entry_pc[PC_W-1]);
  wire          tr_ok   = tr_valid & ~busy;
  wire          st_ok   = st_valid & ~busy;
  wire [IW-1:0] st_slot = st_addr & MASK;
  wire [IW-1:0] tr_slot = tr_head & MASK;
  wire          st_tail = tbl[st_slot][5];
  wire          at_head = ~tbl[walk_ptr][5];
  wire          cap_hit = (walk_cnt >= (IW+1)'(SLOTS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) tbl[i] <= 8'h00;
      busy     <= 1'b0;
      walk_ptr <= '0;
      walk_cnt <= '0;
      lk_ack   <= 1'b0;
      lk_data  <= 8'h00;
      pc_out   <= '0;
    end else begin
      lk_ack <= lk_valid & ~busy;
      if (lk_valid && !busy) lk_data <= tbl[lk_idx & MASK];
      if (entry_stb) pc_out <= {1'b0, entry_pc[PC_W-2:0]};

      if (flush) begin
        for (int i = 0; i < SLOTS; i++) tbl[i] <= 8'h00;
        busy <= 1'b0;
      end else begin
        if (tr_ok) begin
          tbl[tr_slot] <= {1'b1, 1'b0, 1'b0, tr_ext, tr_len};
          for (int k = 1; k < MAX_SPAN; k++)
            if (SPAN_W'(k) < tr_span)
              tbl[(tr_slot + IW'(k)) & MASK] <= 8'h20;
        end
        if (st_ok) begin
          tbl[st_slot][6] <= 1'b1;
          if (st_tail) begin
            busy     <= 1'b1;
            walk_ptr <= (st_slot - IW'(1)) & MASK;
            walk_cnt <= (IW+1)'(1);
          end
        end
        if (busy) begin
          tbl[walk_ptr][6] <= 1'b1;
          if (at_head || cap_hit) begin
            busy <= 1'b0;
          end else begin
            walk_ptr <= (walk_ptr - IW'(1)) & MASK;
            walk_cnt <= walk_cnt + 1'b1;
          end
        end
      end
    end
  end

  assign lk_reuse    = lk_ack & lk_data[7] & ~lk_data[6] & ~lk_data[5];
  assign lk_redecode = lk_ack & lk_data[7] & lk_data[6];
  assign lk_units    = (lk_data[3:0] == 4'd0) ? ZERO_LEN_UNITS : {1'b0, lk_data[3:0]};
endmodule

module xlat_status_tracker_chk #(
  parameter int LOG_SLOTS = 4,
  parameter int PC_W      = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            clear_all,
  input logic            entry_stb,
  input logic [PC_W-1:0] entry_pc,
  input logic [PC_W-1:0] pc_out,
  input logic            st_valid,
  input logic            busy,
  input logic            lk_valid,
  input logic            lk_ack,
  input logic            lk_reuse,
  input logic            lk_redecode
);
  localparam int SLOTS = 1 << LOG_SLOTS;
  logic [LOG_SLOTS+1:0] run;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) run <= '0;
    else if (busy) run <= run + 1'b1;
    else run <= '0;

  // R8
  flush_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clear_all) |-> !busy);
  // R9
  pc_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(entry_stb) |-> (pc_out[PC_W-1] == 1'b0 && pc_out[PC_W-2:0] == $past(entry_pc[PC_W-2:0])));
  // R10
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_ack |-> ($past(lk_valid) && !$past(busy)));
  // R5
  walk_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(st_valid));
  // R5
  walk_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run < (LOG_SLOTS+2)'(SLOTS)));
  // R6
  exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_reuse && lk_redecode));
endmodule

bind xlat_status_tracker xlat_status_tracker_chk #(.LOG_SLOTS(LOG_SLOTS), .PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear_all(clear_all), .entry_stb(entry_stb),
  .entry_pc(entry_pc), .pc_out(pc_out), .st_valid(st_valid), .busy(busy),
  .lk_valid(lk_valid), .lk_ack(lk_ack), .lk_reuse(lk_reuse), .lk_redecode(lk_redecode)
);

// File: tb/tb_xlat_status_tracker.sv
`timescale 1ns/1ps
module tb_xlat_status_tracker;
  logic clk = 0, rst_n = 0;
  logic clear_all = 0, entry_stb = 0;
  logic [15:0] entry_pc = 0, pc_out;
  logic tr_valid = 0, tr_ext = 0, st_valid = 0, lk_valid = 0;
  logic [3:0] tr_head = 0, st_addr = 0, lk_idx = 0, tr_len = 0;
  logic [2:0] tr_span = 0;
  logic busy, lk_ack, lk_reuse, lk_redecode;
  logic [7:0] lk_data;
  logic [4:0] lk_units;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  xlat_status_tracker dut (.*);

  // {op[1:0] 0=translate 1=store 2=lookup, idx[3:0], span[2:0], ext, len[3:0], expected byte}
  localparam int NV = 24;
  localparam logic [21:0] VEC [NV] = '{
    {2'd0,4'd2,3'd3,1'b0,4'd5,8'h00}, {2'd2,4'd2,3'd0,1'b0,4'd0,8'h85},
    {2'd2,4'd3,3'd0,1'b0,4'd0,8'h20}, {2'd2,4'd4,3'd0,1'b0,4'd0,8'h20},
    {2'd2,4'd5,3'd0,1'b0,4'd0,8'h00}, {2'd0,4'd8,3'd1,1'b1,4'd0,8'h00},
    {2'd2,4'd8,3'd0,1'b0,4'd0,8'h90}, {2'd1,4'd10,3'd0,1'b0,4'd0,8'h00},
    {2'd2,4'd10,3'd0,1'b0,4'd0,8'h40}, {2'd1,4'd4,3'd0,1'b0,4'd0,8'h00},
    {2'd2,4'd4,3'd0,1'b0,4'd0,8'h60}, {2'd2,4'd3,3'd0,1'b0,4'd0,8'h60},
    {2'd2,4'd2,3'd0,1'b0,4'd0,8'hC5}, {2'd1,4'd8,3'd0,1'b0,4'd0,8'h00},
    {2'd2,4'd8,3'd0,1'b0,4'd0,8'hD0}, {2'd0,4'd2,3'd1,1'b0,4'd3,8'h00},
    {2'd2,4'd2,3'd0,1'b0,4'd0,8'h83}, {2'd2,4'd3,3'd0,1'b0,4'd0,8'h60},
    {2'd0,4'd15,3'd2,1'b0,4'd7,8'h00}, {2'd2,4'd15,3'd0,1'b0,4'd0,8'h87},
    {2'd2,4'd0,3'd0,1'b0,4'd0,8'h20}, {2'd1,4'd0,3'd0,1'b0,4'd0,8'h00},
    {2'd2,4'd0,3'd0,1'b0,4'd0,8'h60}, {2'd2,4'd15,3'd0,1'b0,4'd0,8'hC7}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wait_idle();
    while (busy) begin @(posedge clk); #1; end
  endtask

  task automatic do_tr(input logic [3:0] h, input logic [2:0] sp, input logic e, input logic [3:0] ln);
    @(negedge clk); tr_valid = 1; tr_head = h; tr_span = sp; tr_ext = e; tr_len = ln;
    @(negedge clk); tr_valid = 0;
  endtask

  task automatic do_st(input logic [3:0] a);
    @(negedge clk); st_valid = 1; st_addr = a;
    @(posedge clk); #1;
    @(negedge clk); st_valid = 0;
    wait_idle();
  endtask

  task automatic look(input logic [3:0] i, input logic [7:0] exp, input string tag);
    @(negedge clk); lk_valid = 1; lk_idx = i;
    @(posedge clk); #1;
    chk(lk_ack === 1'b1, {tag, " ack"}, lk_ack, 1);
    chk(lk_data === exp, tag, lk_data, exp);
    @(negedge clk); lk_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    // R1 reset state
    chk(busy === 1'b0, "R1 busy", busy, 0);
    chk(lk_ack === 1'b0, "R1 ack", lk_ack, 0);
    look(4'd7, 8'h00, "R1 byte");

    for (int v = 0; v < NV; v++) begin
      logic [21:0] e;
      e = VEC[v];
      case (e[21:20])
        2'd0: do_tr(e[19:16], e[15:13], e[12], e[11:8]);
        2'd1: do_st(e[19:16]);
        default: look(e[19:16], e[7:0], $sformatf("R2 R3 R4 R5 vector %0d", v));
      endcase
    end

    // R8 clear_all wipes table
    @(negedge clk); clear_all = 1;
    @(negedge clk); clear_all = 0;
    look(4'd2, 8'h00, "R8 cleared head");
    look(4'd15, 8'h00, "R8 cleared wrap");

    // R5 walk timing, R10 refusal during walk
    do_tr(4'd4, 3'd4, 1'b0, 4'd1);
    @(negedge clk); st_valid = 1; st_addr = 4'd7;
    @(posedge clk); #1;
    chk(busy === 1'b1, "R5 busy rises", busy, 1);
    @(negedge clk); st_addr = 4'd12; tr_valid = 1; tr_head = 4'd13; tr_span = 3'd1; tr_len = 4'd2;
    lk_valid = 1; lk_idx = 4'd4;
    @(posedge clk); #1;
    chk(lk_ack === 1'b0, "R10 lookup stalled", lk_ack, 0);
    @(negedge clk); st_valid = 0; tr_valid = 0; lk_valid = 0;
    n = 2;
    while (busy) begin @(posedge clk); #1; if (busy) n++; end
    chk(n == 3, "R5 busy cycles", n, 3);
    look(4'd4, 8'hC1, "R5 head marked");
    chk(lk_redecode === 1'b1 && lk_reuse === 1'b0, "R6 redecode", {lk_redecode, lk_reuse}, 2);
    look(4'd5, 8'h60, "R5 middle marked");
    look(4'd12, 8'h00, "R10 store ignored");
    look(4'd13, 8'h00, "R10 translate ignored");

    // R6 reuse, R7 zero length
    do_tr(4'd9, 3'd1, 1'b0, 4'd0);
    look(4'd9, 8'h80, "R6 fresh head");
    chk(lk_reuse === 1'b1 && lk_redecode === 1'b0, "R6 reuse", {lk_redecode, lk_reuse}, 1);
    chk(lk_units === 5'd16, "R7 zero length", lk_units, 16);
    look(4'd4, 8'hC1, "R7 nonzero length");
    chk(lk_units === 5'd1, "R7 units", lk_units, 1);

    // R9 entry without and with top bit
    @(negedge clk); entry_stb = 1; entry_pc = 16'h0042;
    @(posedge clk); #1;
    chk(pc_out === 16'h0042, "R9 pc plain", pc_out, 16'h0042);
    @(negedge clk); entry_stb = 0;
    look(4'd9, 8'h80, "R9 table kept");
    @(negedge clk); entry_stb = 1; entry_pc = 16'h8123;
    @(posedge clk); #1;
    chk(pc_out === 16'h0123, "R9 pc top cleared", pc_out, 16'h0123);
    @(negedge clk); entry_stb = 0;
    look(4'd9, 8'h00, "R9 table wiped");

    // R8 clear during walk
    do_tr(4'd1, 3'd3, 1'b0, 4'd2);
    @(negedge clk); st_valid = 1; st_addr = 4'd3;
    @(negedge clk); st_valid = 0; clear_all = 1;
    @(posedge clk); #1;
    chk(busy === 1'b0, "R8 walk ended", busy, 0);
    @(negedge clk); clear_all = 0;
    look(4'd1, 8'h00, "R8 head cleared");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule